// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block guards a processor against a stalled program. A reference stage divides the block clock by a fixed ratio. A selectable binary prescaler of up to eight stages follows it, and then a 15-bit up-counter. If software fails to restart the count before the counter wraps, the block raises a one-cycle reset request for the chip reset generator. It also sets a flag that software can read after the restart to tell a watchdog reset apart from a power-on reset.

Software writes a single 8-bit control byte that cannot be read back. The byte arms the timer, restarts the count, chooses whether counting continues while the processor idles, and picks the prescale code. At power-on, a set of option bits can preset the arming, idle and prescale fields, so the watchdog is already running when the first instruction executes. The power-on reset input returns the whole block to that preset state. A watchdog overflow restarts the counters and reloads the same preset configuration. The reset flag lives in the power-on domain only.

Top module: `wdog_prescaled`

## Requirements
- R1: While `rst_ni` is low, `rst_flag_o` is 0 and `wdt_rst_o` is 0. With `preset_en_i` low, the timer leaves reset disarmed and produces no request however long it waits.
- R2: If `preset_en_i` is high during reset, the arming bit takes `preset_val_i[5]`, the idle-run bit takes `preset_val_i[3]` and the prescale code takes `preset_val_i[2:0]`. A preset of 0x2D leaves the timer armed with idle-run on and code 5.
- R3: From a restart, the request appears after REF_DIV × 2^(code+1) × 2^CNT_W counting cycles. Code 0 divides the reference ticks by 2, and each code step doubles the ratio up to 256 at code 7.
- R4: The request is high for exactly one cycle. On that cycle the counters restart from zero and the control fields reload: from the option bits when `preset_en_i` is high, otherwise to all zero (disarmed).
- R5: The arming bit is control bit 5. Once set, a write with bit 5 at 0 does not disarm the timer; only reset or an overflow reload changes it.
- R6: Writing control bit 4 as 1 restarts the reference divider, the prescaler and the counter at zero, so the next request comes a full period after that write. The bit is not stored.
- R7: Control bit 3 is the idle-run bit. With it at 0, every cycle with `idle_i` high is paused and delays the request by one cycle. With it at 1, `idle_i` has no effect.
- R8: `rst_flag_o` is set in the same cycle as the request. A write with control bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged. An overflow wins over a clearing write in the same cycle.
- R9: While the timer is disarmed, no request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Power-on reset, active low |
| idle_i | input | 1 | High while the processor is in idle mode |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte: 7 flag keep, 5 arm, 4 restart, 3 idle-run, 2:0 prescale code |
| preset_en_i | input | 1 | Apply option bits as the post-reset control value |
| preset_val_i | input | 8 | Option bits, same field positions as the control byte |
| wdt_rst_o | output | 1 | One-cycle reset request on overflow |
| rst_flag_o | output | 1 | Sticky watchdog-reset flag |

## Verification
The assertions check the local rules on every cycle. These are: the request lasts one cycle and comes with the flag, the flag holds until a clearing write, the arming bit never drops without an overflow, a restart write zeroes all stages, a paused idle cycle freezes the counters, and a disarmed timer raises no request. Only the bench scenarios can show the exact period for a given prescale code, the lengthening of the period by the idle cycles, and the option-bit preset after reset. They also show the automatic restart after an overflow when the preset is enabled.

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int CNT_W   = 15,
  parameter int REF_DIV = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       preset_en_i,
  input  logic [7:0] preset_val_i,
  output logic       wdt_rst_o,
  output logic       rst_flag_o
);
  localparam int PRE_W = 8;
  localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  logic             en_q, widl_q, req_q, flag_q;
  logic [2:0]       ps_q;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, mask;
  logic [CNT_W-1:0] cnt_q;

  wire unused_bits = ^{wr_data_i[6], preset_val_i[7:6], preset_val_i[4]};

  wire clr      = wr_en_i & wr_data_i[4];
  wire run      = en_q & ~(idle_i & ~widl_q);
  wire ref_tick = run & (div_q == DIV_W'(REF_DIV - 1));
  wire pre_tick = ref_tick & ((pre_q & mask) == mask);
  wire ovf      = pre_tick & (&cnt_q);

  wire       boot_en   = preset_en_i & preset_val_i[5];
  wire       boot_widl = preset_en_i & preset_val_i[3];
  wire [2:0] boot_ps   = preset_en_i ? preset_val_i[2:0] : 3'd0;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(ps_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr || ovf) begin
      div_q <= '0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      div_q <= ref_tick ? '0 : div_q + 1'b1;
      if (ref_tick) pre_q <= pre_q + 1'b1;
      if (pre_tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= boot_en;
      widl_q <= boot_widl;
      ps_q   <= boot_ps;
    end else if (ovf) begin
      en_q   <= boot_en;
      widl_q <= boot_widl;
      ps_q   <= boot_ps;
    end else if (wr_en_i) begin
      en_q   <= en_q | wr_data_i[5];
      widl_q <= wr_data_i[3];
      ps_q   <= wr_data_i[2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q <= ovf;
      if (ovf) flag_q <= 1'b1;
      else if (wr_en_i && !wr_data_i[7]) flag_q <= 1'b0;
    end
  end

  assign wdt_rst_o  = req_q;
  assign rst_flag_o = flag_q;
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
  parameter int CNT_W = 15,
  parameter int DIV_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic             wdt_rst_o,
  input logic             rst_flag_o,
  input logic             en,
  input logic             widl,
  input logic             ovf,
  input logic [DIV_W-1:0] div,
  input logic [7:0]       pre,
  input logic [CNT_W-1:0] cnt
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R4
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> rst_flag_o); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_flag_o && !(wr_en_i && !wr_data_i[7]) |=> rst_flag_o); // R8
  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !ovf |=> en); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[4] |=> (cnt == '0) && (pre == '0) && (div == '0)); // R6
  AST_IDLE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && !widl && !(wr_en_i && wr_data_i[4]) |=> $stable(cnt) && $stable(pre) && $stable(div)); // R7
  AST_NO_REQ_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !wdt_rst_o); // R9
endmodule

bind wdog_prescaled wdog_prescaled_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .wdt_rst_o(wdt_rst_o), .rst_flag_o(rst_flag_o),
  .en(en_q), .widl(widl_q), .ovf(ovf), .div(div_q), .pre(pre_q), .cnt(cnt_q)
);

// File: tb/sim_wdog_prescaled.sv
module sim_wdog_prescaled;
  localparam int CW = 4;
  localparam int RD = 3;

  logic clk = 0, rst_n = 0, idle = 0, wr_en = 0, pre_en = 0;
  logic [7:0] wr_data = 0, pre_val = 0;
  logic wdt_rst, flag;
  int total = 0, bad = 0, cyc = 0, pulses = 0;
  int exp_cyc[$];
  string exp_req[$];

  wdog_prescaled #(.CNT_W(CW), .REF_DIV(RD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .preset_en_i(pre_en), .preset_val_i(pre_val),
    .wdt_rst_o(wdt_rst), .rst_flag_o(flag));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(int code);
    return RD * (2 << code) * (1 << CW);
  endfunction

  always @(negedge clk) begin
    if (rst_n && wdt_rst) begin
      int e;
      string r;
      pulses++;
      total++;
      if (exp_cyc.size() == 0) begin
        bad++;
        $display("FAIL R9: request at cycle %0d, expected none", cyc);
      end else begin
        e = exp_cyc.pop_front();
        r = exp_req.pop_front();
        if (cyc != e) begin
          bad++;
          $display("FAIL %s: request at cycle %0d, expected %0d", r, cyc, e);
        end
      end
    end
  end

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic expect_at(int n, string r);
    exp_cyc.push_back(cyc + n);
    exp_req.push_back(r);
  endtask

  task automatic drain(string r);
    if (exp_cyc.size() != 0) begin
      int last = exp_cyc[exp_cyc.size()-1];
      while (cyc < last + 3) @(negedge clk);
    end
    total++;
    if (exp_cyc.size() != 0) begin
      bad++;
      $display("FAIL %s: %0d requests missing, expected 0", r, exp_cyc.size());
      exp_cyc.delete(); exp_req.delete();
    end
  endtask

  task automatic chk(int act, int exp, string r);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d, expected %0d", r, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got timeout, expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flag, 0, "R1");
    chk(wdt_rst, 0, "R1");
    rst_n = 1;
    repeat (150) @(negedge clk);
    chk(pulses, 0, "R1");

    // R3 code 0, then R4 disarm after overflow with preset off
    wr(8'h20); expect_at(period(0), "R3"); drain("R3");
    chk(flag, 1, "R8");
    repeat (200) @(negedge clk);
    chk(pulses, 1, "R4");

    // R8 flag keep and clear
    wr(8'h80); chk(flag, 1, "R8");
    wr(8'h00); chk(flag, 0, "R8");

    // R6 restart write, R5 arm stays set
    wr(8'h22); expect_at(period(2), "R6");
    repeat (200) @(negedge clk);
    void'(exp_cyc.pop_back()); void'(exp_req.pop_back());
    wr(8'h32); expect_at(period(2), "R6");
    repeat (50) @(negedge clk);
    wr(8'h02);
    drain("R5");

    // R7 idle pauses when idle-run is off
    wr(8'h20); expect_at(period(0) + 40, "R7");
    repeat (10) @(negedge clk);
    idle = 1; repeat (40) @(negedge clk); idle = 0;
    drain("R7");

    // R7 idle ignored when idle-run is on
    wr(8'h28); expect_at(period(0), "R7");
    repeat (5) @(negedge clk);
    idle = 1; repeat (50) @(negedge clk); idle = 0;
    drain("R7");

    // R3 code 7
    wr(8'h27); expect_at(period(7), "R3"); drain("R3");
    chk(flag, 1, "R8");

    // R2 preset 0x2D, R4 automatic restart
    @(negedge clk); rst_n = 0; pre_en = 1; pre_val = 8'h2D; idle = 1;
    repeat (2) @(negedge clk);
    chk(flag, 0, "R1");
    rst_n = 1;
    expect_at(period(5), "R2");
    expect_at(2 * period(5), "R4");
    drain("R2");
    chk(pulses, 7, "R4");
    finish_up();
  end
endmodule